// File: doc/BRIEF.md
# Wakeup Interrupt Polarity Normaliser

This block stands between a bank of asynchronous wakeup interrupt pins and a downstream interrupt controller that recognises only active-high levels and rising edges. Each pin has its own 32-bit configuration word on a simple register bus. The word selects the pin's trigger type and holds an enable bit. The block synchronises every pin into the local clock. It inverts active-low levels. It turns falling edges into one-cycle pulses, and it turns every transition of a dual-edge pin into a pulse. Each result is gated with the pin's enable before it reaches the downstream controller.

Software rewrites a pin's configuration while that pin's interrupt is masked downstream. A change of polarity can make a steady input look like a new event. For this reason any write to a pin's configuration word blanks that pin's output for one cycle and drops any edge that is being registered at that moment. A read-only identification word lets software see that the per-pin enable sits inside the configuration word.

Top module: `wake_polarity_norm`

## Requirements
- R1: After reset every `wake_out` bit is 0 and every pin's configuration word reads 0x0000_0004 (trigger type level-high, enable clear).
- R2: The word for pin i is at byte address 0x110 + 4*i. Bits [2:0] hold the trigger type and bit 3 holds the enable. A write stores only bits [3:0], and bits [31:4] read as zero. A write to one pin's word leaves every other pin's word unchanged.
- R3: A read sets `bus_rdata` at the clock edge that samples `bus_rd`. Address 0x1000 reads 0x0003_0200, and writes to it have no effect. Any other address outside the configuration array, or not 4-byte aligned, reads 0.
- R4: With type 100 (level high) and the pin enabled, `wake_out` equals the pin input, delayed by three clock edges after the edge that first samples the input.
- R5: With type 000 (level low) and the pin enabled, `wake_out` equals the inverted pin input, with the same latency as R4.
- R6: With type 110 (rising edge) and the pin enabled, each 0-to-1 input transition gives a `wake_out` pulse exactly one cycle long, three edges after the sampling edge. A 1-to-0 transition gives no pulse.
- R7: With type 010 (falling edge) and the pin enabled, each 1-to-0 transition gives a one-cycle pulse with the R6 latency. A 0-to-1 transition gives no pulse.
- R8: With type 111 (dual edge) and the pin enabled, every input transition in either direction gives a one-cycle pulse. This includes transitions on consecutive cycles, which give back-to-back pulses.
- R9: A pin whose enable bit is 0 drives `wake_out` low whatever its type and input.
- R10: The reserved type codes 001, 011 and 101 drive `wake_out` low even when the pin is enabled.
- R11: A write to a pin's configuration word forces that pin's `wake_out` low in the cycle after the write edge, which drops any edge pulse due then. In the next cycle the output follows the new configuration again. Other pins are not affected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wake_in | input | NUM_PINS | Asynchronous wakeup pins |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| wake_out | output | NUM_PINS | Normalised active-high or rising outputs to the downstream controller |

## Verification
The bench builds the block with NUM_PINS = 8 and keeps the default two-stage synchroniser and address map. The whole configuration array therefore sits well below the identification word. The slot just past the last pin (0x130) can then be checked as unmapped, alongside a misaligned address inside the array. With eight lanes, each trigger type gets its own pin, and the unaffected-neighbour parts of R2 and R11 are observed on pins still holding their earlier settings.

// File: rtl/wpn_pkg.sv
package wpn_pkg;

   localparam int DATA_W = 32;

   localparam logic [2:0] TRIG_LVL_LO    = 3'b000;
   localparam logic [2:0] TRIG_EDGE_FALL = 3'b010;
   localparam logic [2:0] TRIG_LVL_HI    = 3'b100;
   localparam logic [2:0] TRIG_EDGE_RISE = 3'b110;
   localparam logic [2:0] TRIG_EDGE_BOTH = 3'b111;

   // bit 3 enable, bits [2:0] trigger type
   typedef struct packed {
      logic       en;
      logic [2:0] trig;
   } pin_cfg_t;

   localparam int CFG_W = $bits(pin_cfg_t);

   localparam pin_cfg_t CFG_RESET = '{en: 1'b0, trig: TRIG_LVL_HI};

endpackage

// File: rtl/wpn_regbank.sv
module wpn_regbank
   import wpn_pkg::*;
#(
   parameter int          NUM_PINS = 32,
   parameter int          ADDR_W   = 13,
   parameter int          CFG_BASE = 32'h110,
   parameter int          VER_ADDR = 32'h1000,
   parameter logic [31:0] VERSION  = 32'h0003_0200
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     bus_wr,
   input  logic                     bus_rd,
   input  logic [ADDR_W-1:0]        bus_addr,
   input  logic [DATA_W-1:0]        bus_wdata,
   output logic [DATA_W-1:0]        bus_rdata,
   output pin_cfg_t [NUM_PINS-1:0]  cfg_o,
   output logic [NUM_PINS-1:0]      cfg_wr_o
);

   localparam logic [ADDR_W-1:0] VER_A = ADDR_W'(VER_ADDR);

   logic [NUM_PINS-1:0] hit;
   logic [DATA_W-1:0]   rd_mux;
   logic                unused_wdata_hi;

   assign unused_wdata_hi = ^bus_wdata[DATA_W-1:CFG_W];

   for (genvar i = 0; i < NUM_PINS; i++) begin : g_word
      localparam logic [ADDR_W-1:0] WORD_A = ADDR_W'(CFG_BASE + 4 * i);
      pin_cfg_t cfg_q;

      assign hit[i]      = (bus_addr == WORD_A);
      assign cfg_wr_o[i] = bus_wr & hit[i];
      assign cfg_o[i]    = cfg_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cfg_q <= CFG_RESET;
         end else if (cfg_wr_o[i]) begin
            cfg_q <= pin_cfg_t'(bus_wdata[CFG_W-1:0]);
         end
      end
   end

   always_comb begin
      rd_mux = '0;
      if (bus_addr == VER_A) begin
         rd_mux = VERSION;
      end
      for (int i = 0; i < NUM_PINS; i++) begin
         if (hit[i]) begin
            rd_mux = {{(DATA_W-CFG_W){1'b0}}, cfg_o[i]};
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bus_rdata <= '0;
      end else if (bus_rd) begin
         bus_rdata <= rd_mux;
      end
   end

endmodule

// File: rtl/wpn_sync.sv
module wpn_sync #(
   parameter int WIDTH  = 32,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] dout
);

   logic [WIDTH-1:0] stg [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stg[0] <= '0;
      end else begin
         stg[0] <= din;
      end
   end

   for (genvar k = 1; k < STAGES; k++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            stg[k] <= '0;
         end else begin
            stg[k] <= stg[k-1];
         end
      end
   end

   assign dout = stg[STAGES-1];

endmodule

// File: rtl/wpn_lane.sv
module wpn_lane
   import wpn_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  pin_cfg_t cfg,
   input  logic     clr,
   input  logic     smp,
   output logic     out
);

   logic prev;
   logic rise;
   logic fall;
   logic norm;

   assign rise = smp & ~prev;
   assign fall = ~smp & prev;

   always_comb begin
      case (cfg.trig)
         TRIG_LVL_HI:    norm = smp;
         TRIG_LVL_LO:    norm = ~smp;
         TRIG_EDGE_RISE: norm = rise;
         TRIG_EDGE_FALL: norm = fall;
         TRIG_EDGE_BOTH: norm = rise | fall;
         default:        norm = 1'b0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev <= 1'b0;
         out  <= 1'b0;
      end else begin
         prev <= smp;
         out  <= clr ? 1'b0 : (cfg.en & norm);
      end
   end

endmodule

// File: rtl/wake_polarity_norm.sv
module wake_polarity_norm
   import wpn_pkg::*;
#(
   parameter int          NUM_PINS    = 32,
   parameter int          SYNC_STAGES = 2,
   parameter int          ADDR_W      = 13,
   parameter int          CFG_BASE    = 32'h110,
   parameter int          VER_ADDR    = 32'h1000,
   parameter logic [31:0] VERSION     = 32'h0003_0200
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_PINS-1:0] wake_in,
   input  logic                bus_wr,
   input  logic                bus_rd,
   input  logic [ADDR_W-1:0]   bus_addr,
   input  logic [31:0]         bus_wdata,
   output logic [31:0]         bus_rdata,
   output logic [NUM_PINS-1:0] wake_out
);

   localparam int CFG_END = CFG_BASE + 4 * NUM_PINS;

   if (NUM_PINS < 1 || NUM_PINS > 256) begin : g_bad_pins
      $error("NUM_PINS must lie in 1..256");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if ((CFG_BASE % 4) != 0 || (VER_ADDR % 4) != 0) begin : g_bad_align
      $error("register addresses must be word aligned");
   end
   if (CFG_END > VER_ADDR && CFG_BASE <= VER_ADDR) begin : g_bad_overlap
      $error("configuration array overlaps the version word");
   end
   if (VER_ADDR >= (1 << ADDR_W) || CFG_END > (1 << ADDR_W)) begin : g_bad_addr_w
      $error("ADDR_W too narrow for the address map");
   end

   pin_cfg_t [NUM_PINS-1:0] cfg;
   logic [NUM_PINS-1:0]     cfg_wr;
   logic [NUM_PINS-1:0]     smp;
   logic [NUM_PINS-1:0]     pin_en;
   logic [3*NUM_PINS-1:0]   pin_trig;

   wpn_regbank #(
      .NUM_PINS (NUM_PINS),
      .ADDR_W   (ADDR_W),
      .CFG_BASE (CFG_BASE),
      .VER_ADDR (VER_ADDR),
      .VERSION  (VERSION)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_wr    (bus_wr),
      .bus_rd    (bus_rd),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .cfg_o     (cfg),
      .cfg_wr_o  (cfg_wr)
   );

   wpn_sync #(
      .WIDTH  (NUM_PINS),
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .din   (wake_in),
      .dout  (smp)
   );

   for (genvar i = 0; i < NUM_PINS; i++) begin : g_lane
      assign pin_en[i]         = cfg[i].en;
      assign pin_trig[3*i +: 3] = cfg[i].trig;

      wpn_lane u_lane (
         .clk   (clk),
         .rst_n (rst_n),
         .cfg   (cfg[i]),
         .clr   (cfg_wr[i]),
         .smp   (smp[i]),
         .out   (wake_out[i])
      );
   end

endmodule

// File: rtl/wpn_chk.sv
module wpn_chk
   import wpn_pkg::*;
#(
   parameter int          NUM_PINS = 32,
   parameter int          ADDR_W   = 13,
   parameter int          CFG_BASE = 32'h110,
   parameter int          VER_ADDR = 32'h1000,
   parameter logic [31:0] VERSION  = 32'h0003_0200
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  bus_wr,
   input logic                  bus_rd,
   input logic [ADDR_W-1:0]     bus_addr,
   input logic [31:0]           bus_rdata,
   input logic [NUM_PINS-1:0]   pin_en,
   input logic [3*NUM_PINS-1:0] pin_trig,
   input logic [NUM_PINS-1:0]   wake_out
);

   // R3
   version_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && bus_addr == ADDR_W'(VER_ADDR)) |=> (bus_rdata == VERSION));

   for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
      localparam logic [ADDR_W-1:0] WORD_A = ADDR_W'(CFG_BASE + 4 * i);

      // R9
      disabled_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !pin_en[i] |=> !wake_out[i]);

      // R10
      reserved_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (pin_trig[3*i +: 3] == 3'b001 || pin_trig[3*i +: 3] == 3'b011 ||
          pin_trig[3*i +: 3] == 3'b101) |=> !wake_out[i]);

      // R6 R7
      edge_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
         ((pin_trig[3*i +: 3] == TRIG_EDGE_RISE || pin_trig[3*i +: 3] == TRIG_EDGE_FALL) &&
          pin_trig[3*i +: 3] == $past(pin_trig[3*i +: 3]) && wake_out[i]) |=> !wake_out[i]);

      // R11
      cfg_write_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (bus_wr && bus_addr == WORD_A) |=> !wake_out[i]);
   end

endmodule

bind wake_polarity_norm wpn_chk #(
   .NUM_PINS (NUM_PINS),
   .ADDR_W   (ADDR_W),
   .CFG_BASE (CFG_BASE),
   .VER_ADDR (VER_ADDR),
   .VERSION  (VERSION)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_wr    (bus_wr),
   .bus_rd    (bus_rd),
   .bus_addr  (bus_addr),
   .bus_rdata (bus_rdata),
   .pin_en    (pin_en),
   .pin_trig  (pin_trig),
   .wake_out  (wake_out)
);

// File: tb/wake_polarity_norm_test.sv
module wake_polarity_norm_test;

   localparam int CLK_PERIOD = 10;
   localparam int N   = 8;
   localparam int LAT = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [N-1:0]  wake_in = '0;
   logic          bus_wr = 1'b0;
   logic          bus_rd = 1'b0;
   logic [12:0]   bus_addr = '0;
   logic [31:0]   bus_wdata = '0;
   logic [31:0]   bus_rdata;
   logic [N-1:0]  wake_out;

   int nchk = 0;
   int nerr = 0;
   int cyc  = 0;
   bit done = 1'b0;

   typedef struct {
      int    at;
      int    pin;
      logic  val;
      string tag;
   } exp_t;

   exp_t sbq[$];

   wake_polarity_norm #(.NUM_PINS(N)) uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .wake_in   (wake_in),
      .bus_wr    (bus_wr),
      .bus_rd    (bus_rd),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .wake_out  (wake_out)
   );

   always #(CLK_PERIOD/2) clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   task automatic check(input bit ok, input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (!ok) begin
         nerr++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   function automatic logic [12:0] cfga(input int p);
      return 13'(32'h110 + 4 * p);
   endfunction

   // driver side: push an expected output bit for a future cycle
   task automatic expect_out(input int ofs, input int pin, input logic val, input string tag);
      exp_t e;
      e.at = cyc + ofs; e.pin = pin; e.val = val; e.tag = tag;
      sbq.push_back(e);
   endtask

   // monitor side
   always @(negedge clk) begin
      if (rst_n) begin
         for (int k = sbq.size() - 1; k >= 0; k--) begin
            if (sbq[k].at == cyc) begin
               check(wake_out[sbq[k].pin] === sbq[k].val, sbq[k].tag, "wake_out bit",
                     32'(wake_out[sbq[k].pin]), 32'(sbq[k].val));
               sbq.delete(k);
            end else if (sbq[k].at < cyc) begin
               check(1'b0, sbq[k].tag, "missed sample", 32'(sbq[k].at), 32'(cyc));
               sbq.delete(k);
            end
         end
      end
   end

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bwrite(input logic [12:0] a, input logic [31:0] d);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0; bus_wdata = '0;
   endtask

   task automatic bread(input logic [12:0] a, input logic [31:0] exp, input string req);
      bus_rd = 1'b1; bus_addr = a;
      @(negedge clk);
      bus_rd = 1'b0;
      check(bus_rdata === exp, req, "read data", bus_rdata, exp);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  Simulation finished: %0d checks, %0d errors", nchk, nerr);
         $finish;
      end
   endtask

   initial begin
      #(CLK_PERIOD * 20000);
      check(1'b0, "watchdog", "run did not complete", 32'(cyc), 32'd0);
      finish_run();
   end

   initial begin
      step(3);
      // R1: outputs low during and after reset
      check(wake_out === '0, "R1", "outputs in reset", 32'(wake_out), 32'd0);
      rst_n = 1'b1;
      step(2);
      check(wake_out === '0, "R1", "outputs after reset", 32'(wake_out), 32'd0);
      bread(cfga(0), 32'h4, "R1");
      bread(cfga(N-1), 32'h4, "R1");

      // R2: field layout, upper bits dropped, neighbour untouched
      bwrite(cfga(2), 32'hFFFF_FFFE);
      bread(cfga(2), 32'h0000_000E, "R2");
      bread(cfga(5), 32'h4, "R2");
      bwrite(cfga(2), 32'h4);
      bread(cfga(2), 32'h4, "R2");

      // R3: identification word and unmapped space
      bread(13'h1000, 32'h0003_0200, "R3");
      bwrite(13'h1000, 32'h0);
      bread(13'h1000, 32'h0003_0200, "R3");
      bread(cfga(N), 32'h0, "R3");
      bread(13'h111, 32'h0, "R3");

      // R4: level high on pin 0
      bwrite(cfga(0), 32'hC);
      step(2);
      wake_in[0] = 1'b1;
      expect_out(LAT-1, 0, 1'b0, "R4");
      expect_out(LAT,   0, 1'b1, "R4");
      expect_out(LAT+3, 0, 1'b1, "R4");
      step(6);
      wake_in[0] = 1'b0;
      expect_out(LAT-1, 0, 1'b1, "R4");
      expect_out(LAT,   0, 1'b0, "R4");
      step(6);

      // R5: level low on pin 1, input idles high
      wake_in[1] = 1'b1;
      step(4);
      bwrite(cfga(1), 32'h8);
      expect_out(2, 1, 1'b0, "R5");
      step(3);
      wake_in[1] = 1'b0;
      expect_out(LAT-1, 1, 1'b0, "R5");
      expect_out(LAT,   1, 1'b1, "R5");
      expect_out(LAT+2, 1, 1'b1, "R5");
      step(6);
      wake_in[1] = 1'b1;
      expect_out(LAT, 1, 1'b0, "R5");
      step(6);

      // R6: rising edge on pin 3
      bwrite(cfga(3), 32'hE);
      step(3);
      wake_in[3] = 1'b1;
      expect_out(LAT-1, 3, 1'b0, "R6");
      expect_out(LAT,   3, 1'b1, "R6");
      expect_out(LAT+1, 3, 1'b0, "R6");
      expect_out(LAT+2, 3, 1'b0, "R6");
      step(6);
      wake_in[3] = 1'b0;
      expect_out(LAT,   3, 1'b0, "R6");
      expect_out(LAT+1, 3, 1'b0, "R6");
      step(6);

      // R7: falling edge on pin 4
      bwrite(cfga(4), 32'hA);
      step(3);
      wake_in[4] = 1'b1;
      expect_out(LAT,   4, 1'b0, "R7");
      expect_out(LAT+1, 4, 1'b0, "R7");
      step(6);
      wake_in[4] = 1'b0;
      expect_out(LAT,   4, 1'b1, "R7");
      expect_out(LAT+1, 4, 1'b0, "R7");
      step(6);

      // R8: dual edge on pin 5, slow then back-to-back transitions
      bwrite(cfga(5), 32'hF);
      step(3);
      wake_in[5] = 1'b1;
      expect_out(LAT,   5, 1'b1, "R8");
      expect_out(LAT+1, 5, 1'b0, "R8");
      step(6);
      wake_in[5] = 1'b0;
      expect_out(LAT,   5, 1'b1, "R8");
      expect_out(LAT+1, 5, 1'b0, "R8");
      step(6);
      wake_in[5] = 1'b1;
      expect_out(LAT,   5, 1'b1, "R8");
      expect_out(LAT+1, 5, 1'b1, "R8");
      expect_out(LAT+2, 5, 1'b0, "R8");
      step(1);
      wake_in[5] = 1'b0;
      step(6);

      // R9: disabled rising-edge pin 6 and disabled level-high pin 7
      bwrite(cfga(6), 32'h6);
      step(2);
      wake_in[6] = 1'b1;
      wake_in[7] = 1'b1;
      expect_out(LAT,   6, 1'b0, "R9");
      expect_out(LAT+1, 6, 1'b0, "R9");
      expect_out(LAT+2, 7, 1'b0, "R9");
      step(6);

      // R10: reserved codes on an enabled pin
      bwrite(cfga(6), 32'h9);
      step(2);
      wake_in[6] = 1'b0;
      expect_out(LAT,   6, 1'b0, "R10");
      expect_out(LAT+2, 6, 1'b0, "R10");
      step(5);
      bwrite(cfga(6), 32'hB);
      step(2);
      wake_in[6] = 1'b1;
      expect_out(LAT,   6, 1'b0, "R10");
      expect_out(LAT+1, 6, 1'b0, "R10");
      step(5);
      bwrite(cfga(6), 32'hD);
      expect_out(3, 6, 1'b0, "R10");
      step(5);

      // R11: write blanks one cycle, neighbour unaffected
      wake_in[0] = 1'b1;
      wake_in[1] = 1'b0;
      step(6);
      expect_out(1, 0, 1'b0, "R11");
      expect_out(2, 0, 1'b1, "R11");
      expect_out(1, 1, 1'b1, "R11");
      bwrite(cfga(0), 32'hC);
      step(4);
      // R11: rising pulse in flight is dropped by a write landing on its edge
      wake_in[3] = 1'b1;
      expect_out(LAT,   3, 1'b0, "R11");
      expect_out(LAT+1, 3, 1'b0, "R11");
      step(2);
      bwrite(cfga(3), 32'hE);
      step(6);

      check(sbq.size() == 0, "scoreboard", "pending items", 32'(sbq.size()), 32'd0);
      finish_run();
   end

endmodule